// File: doc/BRIEF.md
# Memory-Mapped Serial Port With Shared Data Word

This block is a byte-wide asynchronous serial port hung off a 32-bit register bus. Software starts a transmission by writing a byte to the data word and collects a received byte by reading that same word. A single status word reports both whether the transmitter is still shifting and whether a received byte is waiting. Line framing is one start bit, eight data bits least significant first, and one stop bit, with no parity.

The bit period is set by a 13-bit divider register: every bit lasts divider+1 system clocks, for transmit and receive alike. The receive line can come from either of two input pins, chosen by a one-bit select register, and is passed through a two-flop synchronizer that idles high. The receiver holds one byte only. A newer byte replaces an unread older one.

Top module: `serial_port`

## Requirements
- R1: After reset, txd is high, the status word reads 0, the data word reads 0, the pin select reads 0 and the divider reads the DIV_RST parameter.
- R2: A bus write to word 0 (bus_addr 0x0) while the transmitter is idle sends the low 8 bits of bus_wdata on txd as a low start bit, the 8 data bits LSB first, then a high stop bit, each bit lasting divider+1 clocks, beginning right after the write edge; txd idles high.
- R3: Status bit 0 (bus_addr 0x4) is 1 from the write edge for exactly 10*(divider+1) clocks; a write to word 0 while it is 1 is ignored.
- R4: The divider (bus_addr 0x8) is readable and writable; only bus_wdata[12:0] are kept and bits 31:13 read as 0.
- R5: The pin select (bus_addr 0xC) keeps bus_wdata[0]; when 0 the receiver listens to pin_in[7], when 1 to pin_in[3]; activity on the other pin has no effect.
- R6: A received frame's data bits, taken at mid-bit LSB first, are returned by a read of word 0 (bus_addr 0x0) in bits 7:0 with bits 31:8 zero; the value persists after the read.
- R7: Status bit 1 becomes 1 when a frame is accepted and is cleared by a read of word 0 (bus_rd with bus_addr 0x0).
- R8: A frame accepted while a byte is still unread replaces it and leaves status bit 1 set.
- R9: A frame whose stop bit is sampled low is discarded: data word and status bit 1 are unchanged.
- R10: A falling edge on the line that is not still low at half a bit period is treated as noise and produces no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used to consume a received byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr |
| pin_in | input | 8 | Input pins; 7 and 3 are receive candidates |
| txd | output | 1 | Serial transmit line |

## Verification
Assertions check on every cycle that the transmit line is high whenever the transmitter is idle, that every frame starts low and ends on a high stop bit, that an accepted byte lands in the holding register with the available flag set, that a data read clears the flag, that only a high stop bit yields a byte, and that a start is only confirmed on a low mid-bit sample. Whether the bits leave in the right order and period, whether the receive byte matches what was sent on the selected pin, and whether noise, framing errors and the unselected pin are truly ignored can only be shown by the bench scenarios, which compare the line and every register word against a timed model each clock.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    WORD_DATA = 2'd0,
    WORD_STAT = 2'd1,
    WORD_DIV  = 2'd2,
    WORD_SEL  = 2'd3
  } word_e;
endpackage

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int unsigned DIV_W  = 13,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_W = BYTE_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  logic               busy_q, busy_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic [DIV_W-1:0]   tick_q, tick_d;
  logic               en;

  assign en = busy_q | start_i;

  always_comb begin
    busy_d  = busy_q;
    shreg_d = shreg_q;
    bit_d   = bit_q;
    tick_d  = tick_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d  = 1'b1;
        shreg_d = {1'b1, byte_i, 1'b0};
        bit_d   = '0;
        tick_d  = '0;
      end
    end else if (tick_q == div_i) begin
      tick_d  = '0;
      shreg_d = {1'b1, shreg_q[FRAME_W-1:1]};
      if (bit_q == CNT_W'(FRAME_W - 1)) busy_d = 1'b0;
      else                              bit_d  = bit_q + 1'b1;
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      shreg_q <= '1;
      bit_q   <= '0;
      tick_q  <= '0;
    end else if (en) begin
      busy_q  <= busy_d;
      shreg_q <= shreg_d;
      bit_q   <= bit_d;
      tick_q  <= tick_d;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = shreg_q[0];

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_o);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd_o);
  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bit_q == CNT_W'(FRAME_W - 1)) |-> txd_o);
  p_bit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= CNT_W'(FRAME_W - 1));
endmodule

// File: rtl/sp_rx_front.sv
module sp_rx_front #(
  parameter int unsigned PIN_W    = 8,
  parameter int unsigned PIN_MAIN = 7,
  parameter int unsigned PIN_ALT  = 3,
  parameter int unsigned STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_i,
  input  logic             sel_i,
  output logic             rxd_o
);
  logic              raw;
  logic [STAGES-1:0] sync_q;
  logic              unused_pins;

  assign raw         = sel_i ? pin_i[PIN_ALT] : pin_i[PIN_MAIN];
  assign unused_pins = ^pin_i;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign rxd_o = sync_q[STAGES-1];
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int unsigned DIV_W  = 13,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  rx_state_e          state_q, state_d;
  logic               prev_q;
  logic [DIV_W-1:0]   tick_q, tick_d, half;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic [BYTE_W-1:0]  shreg_q, shreg_d, byte_q, byte_d;
  logic               done_q, done_d;

  assign half = div_i >> 1;

  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    shreg_d = shreg_q;
    byte_d  = byte_q;
    done_d  = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (prev_q && !rxd_i) begin
          state_d = RX_START;
          tick_d  = '0;
        end
      end
      RX_START: begin
        if (tick_q == half) begin
          tick_d  = '0;
          bit_d   = '0;
          state_d = rxd_i ? RX_IDLE : RX_DATA;
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (tick_q == div_i) begin
          tick_d  = '0;
          shreg_d = {rxd_i, shreg_q[BYTE_W-1:1]};
          if (bit_q == CNT_W'(BYTE_W - 1)) state_d = RX_STOP;
          else                             bit_d   = bit_q + 1'b1;
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (tick_q == div_i) begin
          tick_d  = '0;
          state_d = RX_IDLE;
          if (rxd_i) begin
            done_d = 1'b1;
            byte_d = shreg_q;
          end
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      prev_q  <= 1'b1;
      tick_q  <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      byte_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      prev_q  <= rxd_i;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      done_q  <= done_d;
      if (done_d) byte_q <= byte_d;
    end
  end

  assign done_o = done_q;
  assign byte_o = byte_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_stop_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(rxd_i));
  p_start_confirmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DATA && $past(state_q) == RX_START) |-> !$past(rxd_i));
endmodule

// File: rtl/serial_port.sv
module serial_port
  import sp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DIV_W    = 13,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PIN_W    = 8,
  parameter int unsigned PIN_MAIN = 7,
  parameter int unsigned PIN_ALT  = 3,
  parameter int unsigned SYNC_N   = 2,
  parameter logic [12:0] DIV_RST  = 13'd63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic              txd
);
  word_e             word;
  logic [DIV_W-1:0]  div_q;
  logic              sel_q;
  logic [BYTE_W-1:0] rx_data_q;
  logic              rx_avail_q, rx_avail_d;
  logic              tx_busy, tx_start, rxd_s, rx_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              wr_div, wr_sel, rd_data;
  logic              unused_bus;

  assign word       = word_e'(bus_addr[3:2]);
  assign unused_bus = ^{bus_addr[1:0], bus_wdata[DATA_W-1:DIV_W]};
  assign tx_start   = bus_wr && word == WORD_DATA;
  assign wr_div     = bus_wr && word == WORD_DIV;
  assign wr_sel     = bus_wr && word == WORD_SEL;
  assign rd_data    = bus_rd && word == WORD_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= DIV_W'(DIV_RST);
    else if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (wr_sel) sel_q <= bus_wdata[0];
  end

  always_comb begin
    rx_avail_d = rx_avail_q;
    if (rd_data) rx_avail_d = 1'b0;
    if (rx_done) rx_avail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_avail_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_avail_q <= rx_avail_d;
      if (rx_done) rx_data_q <= rx_byte;
    end
  end

  always_comb begin
    unique case (word)
      WORD_DATA: bus_rdata = DATA_W'(rx_data_q);
      WORD_STAT: bus_rdata = DATA_W'({rx_avail_q, tx_busy});
      WORD_DIV:  bus_rdata = DATA_W'(div_q);
      WORD_SEL:  bus_rdata = DATA_W'(sel_q);
      default:   bus_rdata = '0;
    endcase
  end

  sp_tx #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) i_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_i   (div_q),
    .start_i (tx_start),
    .byte_i  (bus_wdata[BYTE_W-1:0]),
    .busy_o  (tx_busy),
    .txd_o   (txd)
  );

  sp_rx_front #(.PIN_W(PIN_W), .PIN_MAIN(PIN_MAIN), .PIN_ALT(PIN_ALT),
                .STAGES(SYNC_N)) i_front (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_in),
    .sel_i (sel_q),
    .rxd_o (rxd_s)
  );

  sp_rx #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) i_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (div_q),
    .rxd_i  (rxd_s),
    .done_o (rx_done),
    .byte_o (rx_byte)
  );

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done) |=> !rx_avail_q);
  p_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (rx_avail_q && rx_data_q == $past(rx_byte)));
  p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> $stable(div_q));
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(sel_q));
endmodule

// File: tb/test_serial_port.sv
module test_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'h4;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic        txd;

  serial_port i_serial_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .txd(txd)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  int          cyc = 0;
  int          m_div = 63;
  bit          m_sel = 0;
  bit          m_busy = 0;
  int          m_t = 0;
  logic [7:0]  m_txb = '0;
  logic [7:0]  m_data = '0;
  bit          m_avail = 0;
  int          q_due[$];
  logic [7:0]  q_byte[$];

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  function automatic logic exp_txd();
    logic [9:0] fr;
    if (!m_busy) return 1'b1;
    fr = {1'b1, m_txb, 1'b0};
    return fr[m_t / (m_div + 1)];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 63; m_sel = 0; m_busy = 0; m_t = 0; m_data = '0; m_avail = 0;
    end else begin
      bit was_busy;
      cyc++;
      was_busy = m_busy;
      if (m_busy) begin
        m_t++;
        if (m_t == 10 * (m_div + 1)) m_busy = 0;
      end
      if (bus_wr && bus_addr[3:2] == 2'd0 && !was_busy) begin
        m_busy = 1; m_t = 0; m_txb = bus_wdata[7:0];
      end
      if (bus_wr && bus_addr[3:2] == 2'd2) m_div = int'(bus_wdata[12:0]);
      if (bus_wr && bus_addr[3:2] == 2'd3) m_sel = bus_wdata[0];
      if (bus_rd && bus_addr[3:2] == 2'd0) m_avail = 0;
      while (q_due.size() > 0 && q_due[0] == cyc) begin
        void'(q_due.pop_front());
        m_data  = q_byte.pop_front();
        m_avail = 1;
      end
    end
  end

  // per-clock comparison against the model
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      check("R2 txd", {31'b0, txd}, {31'b0, exp_txd()});
      case (bus_addr[3:2])
        2'd0: check("R6 data word", bus_rdata, {24'b0, m_data});
        2'd1: check("R3/R7 status", bus_rdata, {30'b0, m_avail, m_busy});
        2'd2: check("R4 divider", bus_rdata, 32'(m_div));
        default: check("R5 select", bus_rdata, {31'b0, m_sel});
      endcase
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'h4;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #2;
    v = bus_rdata;
  endtask

  task automatic read_data(output logic [31:0] v);
    @(negedge clk);
    bus_addr = 4'h0; bus_rd = 1'b1;
    #2;
    v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 4'h4;
  endtask

  task automatic wait_tx_idle();
    logic [31:0] v;
    do peek(4'h4, v); while (v[0]);
  endtask

  // drives one frame on pin p; stop_bit 0 makes a framing error
  task automatic send_frame(input int p, input logic [7:0] b, input logic stop_bit);
    int bt, h;
    logic [9:0] fr;
    @(negedge clk);
    bt = m_div + 1;
    h  = m_div / 2;
    fr = {stop_bit, b, 1'b0};
    if (stop_bit && ((p == 7 && !m_sel) || (p == 3 && m_sel))) begin
      q_due.push_back(cyc + 5 + h + 9 * bt);
      q_byte.push_back(b);
    end
    for (int i = 0; i < 10; i++) begin
      pin_in[p] = fr[i];
      repeat (bt) @(negedge clk);
    end
    pin_in[p] = 1'b1;
    repeat (2 * bt + 8) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(4'h4, v); check("R1 status", v, 32'h0);
    peek(4'h0, v); check("R1 data", v, 32'h0);
    peek(4'h8, v); check("R1 divider", v, 32'd63);
    peek(4'hC, v); check("R1 select", v, 32'h0);
    check("R1 txd", {31'b0, txd}, 32'h1);

    // R4 divider width
    bus_write(4'h8, 32'hFFFF_FFFF);
    peek(4'h8, v); check("R4 upper bits", v, 32'h0000_1FFF);
    bus_write(4'h8, 32'd3);
    peek(4'h8, v); check("R4 written", v, 32'd3);

    // R2 transmit, R3 busy and ignored write
    bus_write(4'h0, 32'hFFFF_FFA5);
    repeat (6) @(negedge clk);
    bus_write(4'h0, 32'h3C);
    wait_tx_idle();
    bus_write(4'h0, 32'h01);
    wait_tx_idle();
    check("R3 idle after frames", {31'b0, txd}, 32'h1);

    // R6/R7 receive on pin 7
    send_frame(7, 8'h5A, 1'b1);
    peek(4'h4, v); check("R7 avail set", v, 32'h2);
    read_data(v); check("R6 byte", v, 32'h5A);
    peek(4'h4, v); check("R7 avail cleared", v, 32'h0);
    peek(4'h0, v); check("R6 persists", v, 32'h5A);

    // R8 overwrite
    send_frame(7, 8'h11, 1'b1);
    send_frame(7, 8'h22, 1'b1);
    peek(4'h4, v); check("R8 avail", v, 32'h2);
    read_data(v); check("R8 newer byte", v, 32'h22);

    // R5 pin select
    send_frame(3, 8'h77, 1'b1);
    peek(4'h4, v); check("R5 pin3 ignored", v, 32'h0);
    bus_write(4'hC, 32'hFFFF_FFFF);
    peek(4'hC, v); check("R5 one bit", v, 32'h1);
    send_frame(3, 8'hC3, 1'b1);
    read_data(v); check("R5 pin3 byte", v, 32'hC3);
    send_frame(7, 8'h99, 1'b1);
    peek(4'h4, v); check("R5 pin7 ignored", v, 32'h0);
    peek(4'h0, v); check("R5 data kept", v, 32'hC3);
    bus_write(4'hC, 32'h0);

    // slower rate
    bus_write(4'h8, 32'd7);
    send_frame(7, 8'h96, 1'b1);
    read_data(v); check("R6 byte at div 7", v, 32'h96);

    // R9 framing error
    send_frame(7, 8'h4B, 1'b0);
    peek(4'h4, v); check("R9 no avail", v, 32'h0);
    peek(4'h0, v); check("R9 data kept", v, 32'h96);

    // R10 short glitch
    @(negedge clk); pin_in[7] = 1'b0;
    @(negedge clk); pin_in[7] = 1'b1;
    repeat (120) @(negedge clk);
    peek(4'h4, v); check("R10 no byte", v, 32'h0);
    send_frame(7, 8'h0F, 1'b1);
    read_data(v); check("R10 recovers", v, 32'h0F);

    // concurrent transmit and receive
    bus_write(4'h0, 32'h6E);
    send_frame(7, 8'hE1, 1'b1);
    wait_tx_idle();
    read_data(v); check("R6 during tx", v, 32'hE1);

    repeat (4) @(negedge clk);
    if (q_due.size() != 0) check("R6 pending frames", 32'(q_due.size()), 32'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule